// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block merges every reset cause of a small processor core into a single synchronous system reset. A digital supply-good signal from an analog comparator forces reset at once whenever the supply is out of tolerance. When the supply recovers, a start-up counter keeps reset asserted for a fixed settling interval. This gives the free-running oscillator time to stabilise before the core leaves reset, which models the point where the program starts.

Three other causes feed the same output: an external reset pin that passes through a synchronizer, a reset request from a watchdog, and a hold from an oscillator-fail detector. The reset state does not depend on which source caused it. A sticky power-on flag records that the supply failed. Software reads this flag through a small register port and clears it by writing a one to it.

Top module: `por_rst_seq`

## Requirements
- R1: While `supply_ok` is low, `sys_rst` is 1 with no wait for a clock edge, and the start-up count is held at zero.
- R2: After `supply_ok` goes high with all other sources idle, `sys_rst` stays 1 through rising edge STARTUP_CYCLES-1 and is 0 after rising edge STARTUP_CYCLES. Edges are counted from the first one that sees the supply good, and the default is 65,536.
- R3: A supply drop while running asserts reset at once. The following recovery repeats the full STARTUP_CYCLES count from zero.
- R4: The external pin (active low by default) passes through SYNC_STAGES flops (default 2). `sys_rst` rises after the third rising edge that samples the pin low and stays 1 for as long as the pin is low. Release comes after the third edge that samples it high. There is no automatic release.
- R5: A watchdog request high at a rising edge makes `sys_rst` 1 after that edge. Reset lasts exactly as many cycles as the request.
- R6: An oscillator-fail hold high at a rising edge makes `sys_rst` 1 after that edge. Reset stays 1 until an edge samples the hold low.
- R7: All sources drive one common `sys_rst`. It is released only by a rising edge at which every source is idle.
- R8: `reg_rd_data` bit 0 carries the power-on flag and all its other bits read 0. The flag is set by a supply failure only. Watchdog, external and oscillator-fail resets leave it unchanged.
- R9: A write (`reg_wr_en` high) with `reg_wr_data` bit 0 set clears the flag at that rising edge. A write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, running during reset |
| supply_ok | input | 1 | Comparator output, 1 when supply is in tolerance; also the block's own asynchronous reset |
| ext_rst_pin | input | 1 | External reset pin, polarity set by EXT_ACTIVE_LOW |
| wdt_rst_req | input | 1 | Reset request from the watchdog |
| osc_fail_hold | input | 1 | Reset hold from the oscillator-fail detector |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | REG_W | Register write data, bit 0 clears the power-on flag |
| reg_rd_data | output | REG_W | Register read data, bit 0 is the power-on flag |
| sys_rst | output | 1 | Combined active-high system reset |

## Verification
The bench counts edges exactly at both ends of the start-up interval. A counter that is off by one, or that is not cleared, releases reset one edge early or late. A design that continues counting after a brownout releases reset far too soon. The bench measures the external path at the third edge in each direction, which exposes a synchronizer with a missing or extra stage. It also overlaps sources to catch a release that follows only the most recent cause. The flag tests show whether the flag is set by the wrong sources, cleared by a write of zero, or fails to re-arm on a mid-cycle supply drop.

// File: rtl/por_rst_pkg.sv
package por_rst_pkg;
   localparam int unsigned POR_FLAG_BIT = 0;

   function automatic int unsigned count_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/por_rst_sync.sv
module por_rst_sync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin,
   output logic req_sync
);
   logic pin_act;
   logic [STAGES-1:0] stage_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("por_rst_sync: STAGES must be at least 2");
   end

   if (ACTIVE_LOW) begin : g_low
      assign pin_act = ~pin;
   end else begin : g_high
      assign pin_act = pin;
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_first
         assign d_in = pin_act;
      end else begin : g_next
         assign d_in = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) stage_q[i] <= 1'b1;
         else         stage_q[i] <= d_in;
      end
   end

   assign req_sync = stage_q[STAGES-1];

   assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!arst_n)
      stage_q[0] |=> stage_q[1]);
endmodule

// File: rtl/por_rst_startup.sv
module por_rst_startup
   import por_rst_pkg::*;
#(
   parameter int unsigned LIMIT = 65536
) (
   input  logic clk,
   input  logic supply_ok,
   output logic hold_next
);
   localparam int unsigned CNT_W = count_width(LIMIT);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = (cnt_q == LIMIT_V) ? cnt_q : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok) cnt_q <= '0;
      else            cnt_q <= cnt_d;
   end

   assign hold_next = (cnt_d != LIMIT_V);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!supply_ok)
      (cnt_q != LIMIT_V) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
   assert_count_stays_R2: assert property (@(posedge clk) disable iff (!supply_ok)
      (cnt_q == LIMIT_V) |=> (cnt_q == LIMIT_V));
   assert_count_zero_R1: assert property (@(posedge clk)
      !supply_ok |-> (cnt_q == '0));
endmodule

// File: rtl/por_rst_flag.sv
module por_rst_flag
   import por_rst_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             supply_ok,
   input  logic             clr_req,
   output logic [REG_W-1:0] rd_data
);
   logic flag_q;

   if (REG_W <= POR_FLAG_BIT) begin : g_bad_width
      $error("por_rst_flag: REG_W too small for flag bit");
   end

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok)   flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      rd_data[POR_FLAG_BIT] = flag_q;
   end

   assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!supply_ok)
      clr_req |=> !rd_data[POR_FLAG_BIT]);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      (rd_data[POR_FLAG_BIT] && !clr_req) |=> rd_data[POR_FLAG_BIT]);
   assert_flag_no_set_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      !rd_data[POR_FLAG_BIT] |=> !rd_data[POR_FLAG_BIT]);
endmodule

// File: rtl/por_rst_seq.sv
module por_rst_seq
   import por_rst_pkg::*;
#(
   parameter int unsigned STARTUP_CYCLES = 65536,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned REG_W          = 8,
   parameter bit          EXT_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             supply_ok,
   input  logic             ext_rst_pin,
   input  logic             wdt_rst_req,
   input  logic             osc_fail_hold,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   output logic             sys_rst
);
   logic ext_req;
   logic settle_hold;
   logic rst_d;
   logic rst_q;
   logic unused_wr_bits;

   if (STARTUP_CYCLES < SYNC_STAGES + 1) begin : g_bad_startup
      $error("por_rst_seq: STARTUP_CYCLES must exceed SYNC_STAGES");
   end

   por_rst_sync #(
      .STAGES     (SYNC_STAGES),
      .ACTIVE_LOW (EXT_ACTIVE_LOW)
   ) u_ext_sync (
      .clk      (clk),
      .arst_n   (supply_ok),
      .pin      (ext_rst_pin),
      .req_sync (ext_req)
   );

   por_rst_startup #(
      .LIMIT (STARTUP_CYCLES)
   ) u_startup (
      .clk       (clk),
      .supply_ok (supply_ok),
      .hold_next (settle_hold)
   );

   por_rst_flag #(
      .REG_W (REG_W)
   ) u_flag (
      .clk       (clk),
      .supply_ok (supply_ok),
      .clr_req   (reg_wr_en & reg_wr_data[POR_FLAG_BIT]),
      .rd_data   (reg_rd_data)
   );

   assign unused_wr_bits = ^reg_wr_data;

   assign rst_d = settle_hold | ext_req | wdt_rst_req | osc_fail_hold;

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok) rst_q <= 1'b1;
      else            rst_q <= rst_d;
   end

   assign sys_rst = rst_q;

   assert_supply_hold_R1: assert property (@(posedge clk)
      !supply_ok |-> sys_rst);
   assert_wdt_reset_R5: assert property (@(posedge clk) disable iff (!supply_ok)
      wdt_rst_req |=> sys_rst);
   assert_osc_reset_R6: assert property (@(posedge clk) disable iff (!supply_ok)
      osc_fail_hold |=> sys_rst);
   assert_ext_reset_R4: assert property (@(posedge clk) disable iff (!supply_ok)
      ext_req |=> sys_rst);
   assert_release_idle_R7: assert property (@(posedge clk) disable iff (!supply_ok)
      $fell(sys_rst) |-> $past(!wdt_rst_req && !osc_fail_hold && !ext_req));
endmodule

// File: tb/por_rst_seq_tb_top.sv
module por_rst_seq_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  STARTUP    = 100;
   localparam int  REG_W      = 8;
   localparam int  WD_LIMIT   = 5000;

   logic             clk = 1'b0;
   logic             supply_ok;
   logic             ext_rst_pin;
   logic             wdt_rst_req;
   logic             osc_fail_hold;
   logic             reg_wr_en;
   logic [REG_W-1:0] reg_wr_data;
   logic [REG_W-1:0] reg_rd_data;
   logic             sys_rst;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   por_rst_seq #(
      .STARTUP_CYCLES (STARTUP),
      .SYNC_STAGES    (2),
      .REG_W          (REG_W),
      .EXT_ACTIVE_LOW (1'b1)
   ) dut_i (
      .clk           (clk),
      .supply_ok     (supply_ok),
      .ext_rst_pin   (ext_rst_pin),
      .wdt_rst_req   (wdt_rst_req),
      .osc_fail_hold (osc_fail_hold),
      .reg_wr_en     (reg_wr_en),
      .reg_wr_data   (reg_wr_data),
      .reg_rd_data   (reg_rd_data),
      .sys_rst       (sys_rst)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset_state();
      #1 supply_ok = 1'b0;
      #1;
      chk("R1", "reset asserted while supply bad", 32'(sys_rst), 1);
      chk("R8", "flag set by supply failure", 32'(reg_rd_data), 1);
      repeat (3) tick();
      chk("R1", "reset held over edges", 32'(sys_rst), 1);
   endtask

   task automatic t_powerup();
      supply_ok = 1'b1;
      repeat (STARTUP - 1) tick();
      chk("R2", "reset still held at edge N-1", 32'(sys_rst), 1);
      tick();
      chk("R2", "reset released at edge N", 32'(sys_rst), 0);
      chk("R8", "flag survives start-up", 32'(reg_rd_data), 1);
   endtask

   task automatic t_flag_rw();
      reg_wr_en = 1'b1; reg_wr_data = 8'hFE;
      tick();
      reg_wr_en = 1'b0;
      chk("R9", "write of zero to flag bit ignored", 32'(reg_rd_data), 1);
      reg_wr_data = 8'h01;
      tick();
      chk("R9", "flag kept without write strobe", 32'(reg_rd_data), 1);
      reg_wr_en = 1'b1;
      tick();
      reg_wr_en = 1'b0; reg_wr_data = '0;
      chk("R9", "write one clears flag", 32'(reg_rd_data), 0);
      chk("R2", "no reset from flag access", 32'(sys_rst), 0);
   endtask

   task automatic t_ext();
      ext_rst_pin = 1'b0;
      tick(); tick();
      chk("R4", "no reset after two edges", 32'(sys_rst), 0);
      tick();
      chk("R4", "reset on third edge", 32'(sys_rst), 1);
      repeat (20) tick();
      chk("R4", "no auto release", 32'(sys_rst), 1);
      ext_rst_pin = 1'b1;
      tick(); tick();
      chk("R4", "still held two edges after release", 32'(sys_rst), 1);
      tick();
      chk("R4", "released on third edge", 32'(sys_rst), 0);
      chk("R8", "external reset leaves flag clear", 32'(reg_rd_data), 0);
   endtask

   task automatic t_wdt();
      wdt_rst_req = 1'b1;
      tick();
      chk("R5", "watchdog pulse asserts reset", 32'(sys_rst), 1);
      wdt_rst_req = 1'b0;
      tick();
      chk("R5", "one-cycle pulse gives one-cycle reset", 32'(sys_rst), 0);
      chk("R8", "watchdog leaves flag clear", 32'(reg_rd_data), 0);
   endtask

   task automatic t_osc();
      osc_fail_hold = 1'b1;
      tick();
      repeat (9) tick();
      chk("R6", "oscillator hold keeps reset", 32'(sys_rst), 1);
      osc_fail_hold = 1'b0;
      tick();
      chk("R6", "reset drops after hold ends", 32'(sys_rst), 0);
      chk("R8", "oscillator fail leaves flag clear", 32'(reg_rd_data), 0);
   endtask

   task automatic t_overlap();
      osc_fail_hold = 1'b1; wdt_rst_req = 1'b1;
      tick();
      wdt_rst_req = 1'b0; ext_rst_pin = 1'b0;
      repeat (5) tick();
      osc_fail_hold = 1'b0;
      tick();
      chk("R7", "external source keeps common reset", 32'(sys_rst), 1);
      ext_rst_pin = 1'b1;
      tick(); tick();
      chk("R7", "held until last source clears", 32'(sys_rst), 1);
      tick();
      chk("R7", "released when all idle", 32'(sys_rst), 0);
   endtask

   task automatic t_brownout();
      @(posedge clk);
      #2 supply_ok = 1'b0;
      #1;
      chk("R3", "mid-cycle drop asserts reset at once", 32'(sys_rst), 1);
      chk("R8", "drop re-sets flag", 32'(reg_rd_data), 1);
      repeat (4) tick();
      supply_ok = 1'b1;
      repeat (STARTUP / 2) tick();
      chk("R3", "held halfway through recovery", 32'(sys_rst), 1);
      repeat (STARTUP / 2 - 1) tick();
      chk("R3", "held at edge N-1 of recovery", 32'(sys_rst), 1);
      tick();
      chk("R3", "full count repeated then release", 32'(sys_rst), 0);
   endtask

   initial begin
      supply_ok     = 1'b1;
      ext_rst_pin   = 1'b1;
      wdt_rst_req   = 1'b0;
      osc_fail_hold = 1'b0;
      reg_wr_en     = 1'b0;
      reg_wr_data   = '0;
      t_reset_state();
      t_powerup();
      t_flag_rw();
      t_ext();
      t_wdt();
      t_osc();
      t_overlap();
      t_brownout();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired (R1 to R9 sequence hung)");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule